// File: doc/BRIEF.md
# Lockable Scratchpad Memory Command Engine

This block is the memory-command stage of a single-wire serial memory target. It runs after device selection has finished, takes whole bytes that a bit-level receiver has already assembled, and returns bytes for the bit-level transmitter to send. It holds a 32-byte data memory with its own 32-byte staging buffer (the scratchpad). It also holds an 8-byte one-time-programmable application register with an 8-byte staging buffer, and a status byte that reports whether that register has been locked.

Every command starts with a command byte. Most commands then take a start address, and the address steps through the selected area with wrap-around. The two copy commands only act after a key byte, and start a self-timed programming interval. The command ends when the bus reset input is pulsed. Non-volatile storage is modelled as flops, and the programming interval is modelled as a counter of `PROG_CYCLES` clock cycles. While that interval runs, the engine reports busy and discards received bytes.

The application register can be programmed only once. After it is locked, read commands for it return the locked contents instead of the staging buffer, and the write and lock commands no longer take effect.

Top module: `owm_otp_engine`

## Requirements
- R1: After `rst_n` is deasserted, all storage reads 00h, the register is unlocked, `busy` is 0 and `tx_avail` is 0.
- R2: Command 0Fh, then an address byte (only bits 4:0 are used), then data bytes: each data byte is written to the data scratchpad and the address advances, with 1Fh wrapping to 00h.
- R3: Command AAh, then an address byte: `tx_avail` rises and `tx_data` shows the scratchpad byte at that address. Each `tx_ack` advances the address, with 1Fh wrapping to 00h.
- R4: Command 55h followed by key A5h raises `busy` for exactly `PROG_CYCLES` cycles, starting on the edge that accepts the key. When `busy` falls, data memory equals the scratchpad. Any other key byte, or a bus reset in place of the key, starts no interval and copies nothing.
- R5: Command F0h copies all of data memory into the scratchpad as soon as the command byte is accepted, even if a bus reset follows at once. An address byte then starts a read of the scratchpad with the same wrap as R3.
- R6: Command 99h, then an address byte (only bits 2:0 are used), then data bytes: each byte is written to the register scratchpad, with 07h wrapping to 00h. Once the register is locked, these writes are discarded.
- R7: Command 66h followed by key 00h makes the status byte available on every read. The status byte is FFh while unlocked and FCh once locked. Any other key returns nothing.
- R8: Command C3h, then an address byte (bits 2:0), reads the register scratchpad while unlocked and the locked register once locked, with 07h wrapping to 00h.
- R9: Command 5Ah followed by key A5h raises `busy` for `PROG_CYCLES` cycles, then copies the register scratchpad into the application register and sets the lock permanently. A bus reset in place of the key cancels the command. Once locked, the command starts no interval.
- R10: While `busy` is 1, received bytes are discarded and start no command.
- R11: An unknown command byte leaves the engine idle, with received bytes ignored, until a bus reset.
- R12: A bus reset ends any command. `tx_avail` is 0 on the next cycle, and the next received byte is taken as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; clears all storage and the lock |
| bus_rst | input | 1 | Bus reset pulse; ends the current command |
| rx_valid | input | 1 | A received byte is present for one cycle |
| rx_byte | input | 8 | Received byte |
| tx_ack | input | 1 | The transmitter has taken the current output byte |
| tx_avail | output | 1 | An output byte is available on `tx_data` |
| tx_data | output | 8 | Byte to transmit |
| busy | output | 1 | Programming interval in progress |

## Verification
The embedded assertions check several rules on every cycle. Busy must follow a copy start. The programming counter stays inside its range. No write or copy strobe fires while busy. A bus reset removes the output byte. An unknown command keeps the engine idle. The lock stays set and freezes the application register, and data memory changes only when a data copy completes.

The bench scenarios are needed for the rules that depend on content. These include the address wrap of each area and the masking of the address bits. They also include the reload done by Read Memory, rejection of a wrong key, and cancelling a copy by bus reset. Finally, they show the switch of the register read source at lock time, the discarded writes after lock, and the exact length of the busy interval.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam logic [7:0] CMD_WR_SP    = 8'h0F;
    localparam logic [7:0] CMD_RD_SP    = 8'hAA;
    localparam logic [7:0] CMD_CP_SP    = 8'h55;
    localparam logic [7:0] CMD_RD_MEM   = 8'hF0;
    localparam logic [7:0] CMD_WR_AR    = 8'h99;
    localparam logic [7:0] CMD_RD_STAT  = 8'h66;
    localparam logic [7:0] CMD_RD_AR    = 8'hC3;
    localparam logic [7:0] CMD_CP_LOCK  = 8'h5A;

    localparam logic [7:0] KEY_COPY     = 8'hA5;
    localparam logic [7:0] KEY_STATUS   = 8'h00;

    localparam logic [7:0] STAT_OPEN    = 8'hFF;
    localparam logic [7:0] STAT_LOCKED  = 8'hFC;

    typedef enum logic [2:0] {
        ST_CMD, ST_ADDR, ST_WR, ST_RD, ST_KEY, ST_HOLD
    } eng_state_e;

    typedef enum logic [2:0] {
        OP_WSP, OP_RSP, OP_CPSP, OP_RMEM, OP_WAR, OP_RSTAT, OP_RAR, OP_LOCK
    } eng_op_e;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_APP  = 1'b1
    } copy_kind_e;

endpackage

// File: rtl/owm_prog_timer.sv
module owm_prog_timer
    import owm_pkg::*;
#(
    parameter int PROG_CYCLES = 500,
    localparam int CW = $clog2(PROG_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  copy_kind_e start_kind,
    output logic       busy,
    output logic       done,
    output copy_kind_e done_kind
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        copy_kind_e    kind;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (q.cnt != '0) begin
            d.cnt = q.cnt - CW'(1);
        end else if (start) begin
            d.cnt  = CW'(PROG_CYCLES);
            d.kind = start_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, kind: KIND_DATA};
        else        q <= d;
    end

    assign busy      = (q.cnt != '0);
    assign done      = (q.cnt == CW'(1));
    assign done_kind = q.kind;

    // R4
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(PROG_CYCLES));

endmodule

// File: rtl/owm_store.sv
module owm_store
    import owm_pkg::*;
#(
    parameter int DATA_BYTES = 32,
    parameter int APP_BYTES  = 8,
    localparam int DA_W = $clog2(DATA_BYTES),
    localparam int AA_W = $clog2(APP_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_to_sp,
    input  logic            sp_we,
    input  logic [DA_W-1:0] sp_waddr,
    input  logic [7:0]      sp_wdata,
    input  logic            rs_we,
    input  logic [AA_W-1:0] rs_waddr,
    input  logic [7:0]      rs_wdata,
    input  logic            prog_done,
    input  copy_kind_e      prog_kind,
    input  logic [DA_W-1:0] sp_raddr,
    output logic [7:0]      sp_rdata,
    input  logic [AA_W-1:0] ar_raddr,
    output logic [7:0]      ar_rdata,
    output logic            lock,
    output logic [7:0]      status
);

    typedef struct packed {
        logic [DATA_BYTES-1:0][7:0] mem;
        logic [DATA_BYTES-1:0][7:0] sp;
        logic [APP_BYTES-1:0][7:0]  app;
        logic [APP_BYTES-1:0][7:0]  rs;
        logic                       lock;
    } store_t;

    store_t q, d;

    always_comb begin
        d = q;
        if (mem_to_sp) begin
            d.sp = q.mem;
        end else if (sp_we) begin
            d.sp[sp_waddr] = sp_wdata;
        end
        if (rs_we && !q.lock) begin
            d.rs[rs_waddr] = rs_wdata;
        end
        if (prog_done) begin
            if (prog_kind == KIND_DATA) begin
                d.mem = q.sp;
            end else if (!q.lock) begin
                d.app  = q.rs;
                d.lock = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sp_rdata = q.sp[sp_raddr];
    assign ar_rdata = q.lock ? q.app[ar_raddr] : q.rs[ar_raddr];
    assign lock     = q.lock;
    assign status   = q.lock ? STAT_LOCKED : STAT_OPEN;

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> q.lock);

    // R9
    app_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> $stable(q.app));

    // R4
    mem_only_on_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_done && prog_kind == KIND_DATA) |=> $stable(q.mem));

endmodule

// File: rtl/owm_cmd_fsm.sv
module owm_cmd_fsm
    import owm_pkg::*;
#(
    parameter int DATA_BYTES = 32,
    parameter int APP_BYTES  = 8,
    localparam int DA_W = $clog2(DATA_BYTES),
    localparam int AA_W = $clog2(APP_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_rst,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            tx_ack,
    input  logic            busy,
    input  logic            lock,
    input  logic [7:0]      sp_rdata,
    input  logic [7:0]      ar_rdata,
    input  logic [7:0]      status,
    output logic            tx_avail,
    output logic [7:0]      tx_data,
    output logic            mem_to_sp,
    output logic            sp_we,
    output logic [DA_W-1:0] sp_waddr,
    output logic [7:0]      sp_wdata,
    output logic            rs_we,
    output logic [AA_W-1:0] rs_waddr,
    output logic [7:0]      rs_wdata,
    output logic [DA_W-1:0] sp_raddr,
    output logic [AA_W-1:0] ar_raddr,
    output logic            prog_start,
    output copy_kind_e      prog_kind
);

    typedef struct packed {
        eng_state_e      st;
        eng_op_e         op;
        logic [DA_W-1:0] addr;
    } fsm_t;

    fsm_t q, d;

    function automatic logic [DA_W-1:0] step_addr(eng_op_e op, logic [DA_W-1:0] a);
        if (op == OP_WAR || op == OP_RAR) return DA_W'(a[AA_W-1:0] + AA_W'(1));
        else                              return a + DA_W'(1);
    endfunction

    always_comb begin
        d          = q;
        mem_to_sp  = 1'b0;
        sp_we      = 1'b0;
        rs_we      = 1'b0;
        prog_start = 1'b0;
        prog_kind  = KIND_DATA;

        if (bus_rst) begin
            d.st = ST_CMD;
        end else if (rx_valid && !busy) begin
            case (q.st)
                ST_CMD: begin
                    case (rx_byte)
                        CMD_WR_SP:   begin d.st = ST_ADDR; d.op = OP_WSP;   end
                        CMD_RD_SP:   begin d.st = ST_ADDR; d.op = OP_RSP;   end
                        CMD_CP_SP:   begin d.st = ST_KEY;  d.op = OP_CPSP;  end
                        CMD_RD_MEM:  begin d.st = ST_ADDR; d.op = OP_RMEM;
                                           mem_to_sp = 1'b1;                end
                        CMD_WR_AR:   begin d.st = ST_ADDR; d.op = OP_WAR;   end
                        CMD_RD_STAT: begin d.st = ST_KEY;  d.op = OP_RSTAT; end
                        CMD_RD_AR:   begin d.st = ST_ADDR; d.op = OP_RAR;   end
                        CMD_CP_LOCK: begin d.st = ST_KEY;  d.op = OP_LOCK;  end
                        default:           d.st = ST_HOLD;
                    endcase
                end
                ST_ADDR: begin
                    if (q.op == OP_WAR || q.op == OP_RAR) d.addr = DA_W'(rx_byte[AA_W-1:0]);
                    else                                  d.addr = rx_byte[DA_W-1:0];
                    d.st = (q.op == OP_WSP || q.op == OP_WAR) ? ST_WR : ST_RD;
                end
                ST_WR: begin
                    if (q.op == OP_WSP) sp_we = 1'b1;
                    else                rs_we = !lock;
                    d.addr = step_addr(q.op, q.addr);
                end
                ST_KEY: begin
                    d.st = ST_HOLD;
                    case (q.op)
                        OP_CPSP: if (rx_byte == KEY_COPY) begin
                            prog_start = 1'b1;
                            prog_kind  = KIND_DATA;
                        end
                        OP_LOCK: if (rx_byte == KEY_COPY && !lock) begin
                            prog_start = 1'b1;
                            prog_kind  = KIND_APP;
                        end
                        OP_RSTAT: if (rx_byte == KEY_STATUS) d.st = ST_RD;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end else if (tx_ack && q.st == ST_RD && q.op != OP_RSTAT) begin
            d.addr = step_addr(q.op, q.addr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_CMD, op: OP_WSP, addr: '0};
        else        q <= d;
    end

    assign sp_waddr = q.addr;
    assign sp_wdata = rx_byte;
    assign rs_waddr = q.addr[AA_W-1:0];
    assign rs_wdata = rx_byte;
    assign sp_raddr = q.addr;
    assign ar_raddr = q.addr[AA_W-1:0];
    assign tx_avail = (q.st == ST_RD);

    always_comb begin
        case (q.op)
            OP_RAR:   tx_data = ar_rdata;
            OP_RSTAT: tx_data = status;
            default:  tx_data = sp_rdata;
        endcase
    end

    // R10
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(prog_start || sp_we || rs_we || mem_to_sp));

    // R12
    bus_rst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !tx_avail);

    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && !bus_rst) |=> (q.st == ST_HOLD && !tx_avail));

endmodule

// File: rtl/owm_otp_engine.sv
module owm_otp_engine
    import owm_pkg::*;
#(
    parameter int DATA_BYTES  = 32,
    parameter int APP_BYTES   = 8,
    parameter int PROG_CYCLES = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_ack,
    output logic       tx_avail,
    output logic [7:0] tx_data,
    output logic       busy
);

    localparam int DA_W = $clog2(DATA_BYTES);
    localparam int AA_W = $clog2(APP_BYTES);

    logic            mem_to_sp, sp_we, rs_we, prog_start, prog_done, lock;
    logic [DA_W-1:0] sp_waddr, sp_raddr;
    logic [AA_W-1:0] rs_waddr, ar_raddr;
    logic [7:0]      sp_wdata, rs_wdata, sp_rdata, ar_rdata, status;
    copy_kind_e      start_kind, done_kind;

    owm_cmd_fsm #(.DATA_BYTES(DATA_BYTES), .APP_BYTES(APP_BYTES)) u_fsm (
        .clk, .rst_n, .bus_rst, .rx_valid, .rx_byte, .tx_ack,
        .busy, .lock, .sp_rdata, .ar_rdata, .status,
        .tx_avail, .tx_data, .mem_to_sp, .sp_we, .sp_waddr, .sp_wdata,
        .rs_we, .rs_waddr, .rs_wdata, .sp_raddr, .ar_raddr,
        .prog_start, .prog_kind(start_kind)
    );

    owm_store #(.DATA_BYTES(DATA_BYTES), .APP_BYTES(APP_BYTES)) u_store (
        .clk, .rst_n, .mem_to_sp, .sp_we, .sp_waddr, .sp_wdata,
        .rs_we, .rs_waddr, .rs_wdata, .prog_done, .prog_kind(done_kind),
        .sp_raddr, .sp_rdata, .ar_raddr, .ar_rdata, .lock, .status
    );

    owm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk, .rst_n, .start(prog_start), .start_kind,
        .busy, .done(prog_done), .done_kind
    );

endmodule

// File: tb/tb_owm_otp_engine.sv
module tb_owm_otp_engine;

    localparam int PROG = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_ack = 1'b0;
    logic       tx_avail;
    logic [7:0] tx_data;
    logic       busy;

    owm_otp_engine #(.DATA_BYTES(32), .APP_BYTES(8), .PROG_CYCLES(PROG)) dut (
        .clk, .rst_n, .bus_rst, .rx_valid, .rx_byte, .tx_ack,
        .tx_avail, .tx_data, .busy
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [7:0] m_sp [32];
    logic [7:0] m_mem[32];
    logic [7:0] m_rs [8];
    logic [7:0] m_app[8];
    bit         m_lock;

    function automatic logic [7:0] stat_exp(bit lk);
        return lk ? 8'hFC : 8'hFF;
    endfunction

    function automatic int wrap_d(int a);
        return a % 32;
    endfunction

    function automatic int wrap_a(int a);
        return a % 8;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic breset();
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, "tx_avail", int'(tx_avail), 1);
        chk(req, "tx_data", int'(tx_data), int'(exp));
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int s;
        logic [7:0] b;
        void'($urandom(32'h5EED_0A17));
        m_lock = 1'b0;
        for (int i = 0; i < 32; i++) begin m_sp[i] = 8'h00; m_mem[i] = 8'h00; end
        for (int i = 0; i < 8; i++)  begin m_rs[i] = 8'h00; m_app[i] = 8'h00; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "tx_avail", int'(tx_avail), 0);
        chk("R1", "busy", int'(busy), 0);
        send(8'h66); send(8'h00);
        rd("R1", stat_exp(0));
        rd("R7", stat_exp(0));
        breset();
        send(8'hF0); send(8'h00);
        for (int i = 0; i < 32; i++) rd("R1", 8'h00);
        breset();

        // R2: random start, upper address bits set, 40 bytes so it wraps
        s = int'($urandom % 32);
        send(8'hAA); send(8'h00);
        breset();
        send(8'h0F); send(8'(s) | 8'hE0);
        for (int i = 0; i < 40; i++) begin
            b = 8'($urandom);
            send(b);
            m_sp[wrap_d(s + i)] = b;
        end
        breset();
        // R3: read across the 1Fh to 00h wrap
        send(8'hAA); send(8'd30);
        for (int i = 0; i < 34; i++) rd("R3", m_sp[wrap_d(30 + i)]);
        breset();

        // R4: wrong key and cancelled key start nothing
        send(8'h55); send(8'h5A);
        @(negedge clk);
        chk("R4", "busy after wrong key", int'(busy), 0);
        breset();
        send(8'h55);
        breset();
        @(negedge clk);
        chk("R4", "busy after cancel", int'(busy), 0);
        send(8'hF0); send(8'h00);
        for (int i = 0; i < 4; i++) rd("R4", 8'h00);
        breset();
        // sp now reloaded with zeros by Read Memory; rewrite it
        for (int i = 0; i < 32; i++) m_sp[i] = m_mem[i];
        send(8'h0F); send(8'h00);
        for (int i = 0; i < 32; i++) begin
            b = 8'($urandom);
            send(b);
            m_sp[i] = b;
        end
        breset();

        // R4: valid copy and exact interval length
        send(8'h55); send(8'hA5);
        count_busy(n);
        chk("R4", "busy cycles", n, PROG);
        for (int i = 0; i < 32; i++) m_mem[i] = m_sp[i];
        breset();

        // R10: bytes during busy are dropped
        send(8'h55); send(8'hA5);
        send(8'hAA); send(8'h03);
        @(negedge clk);
        chk("R10", "busy", int'(busy), 1);
        chk("R10", "tx_avail in busy", int'(tx_avail), 0);
        while (busy) @(negedge clk);
        chk("R10", "tx_avail after busy", int'(tx_avail), 0);
        breset();

        // R5: reload with immediate bus reset
        send(8'h0F); send(8'h04);
        for (int i = 0; i < 3; i++) begin
            b = 8'($urandom);
            send(b);
            m_sp[4 + i] = b;
        end
        breset();
        send(8'hF0);
        breset();
        for (int i = 0; i < 32; i++) m_sp[i] = m_mem[i];
        send(8'hAA); send(8'h00);
        for (int i = 0; i < 32; i++) rd("R5", m_sp[i]);
        breset();
        send(8'hF0); send(8'h05);
        for (int i = 0; i < 33; i++) rd("R5", m_mem[wrap_d(5 + i)]);
        breset();

        // R11: unknown command
        send(8'h12); send(8'hAA); send(8'h00);
        @(negedge clk);
        chk("R11", "tx_avail", int'(tx_avail), 0);
        // R12: bus reset recovers, and ends a read
        breset();
        send(8'hAA); send(8'h07);
        rd("R12", m_sp[7]);
        breset();
        @(negedge clk);
        chk("R12", "tx_avail after reset", int'(tx_avail), 0);

        // R7: wrong status key
        send(8'h66); send(8'h01);
        @(negedge clk);
        chk("R7", "tx_avail wrong key", int'(tx_avail), 0);
        breset();

        // R6: register scratchpad write with wrap, upper address bits ignored
        send(8'h99); send(8'h0E);
        for (int i = 0; i < 10; i++) begin
            b = 8'($urandom);
            send(b);
            m_rs[wrap_a(6 + i)] = b;
        end
        breset();
        // R8: unlocked read returns register scratchpad
        send(8'hC3); send(8'h00);
        for (int i = 0; i < 10; i++) rd("R8", m_rs[wrap_a(i)]);
        breset();

        // R9: cancel by bus reset in place of key
        send(8'h5A);
        breset();
        @(negedge clk);
        chk("R9", "busy after cancel", int'(busy), 0);
        send(8'h66); send(8'h00);
        rd("R9", stat_exp(0));
        breset();

        // R9: lock
        send(8'h5A); send(8'hA5);
        count_busy(n);
        chk("R9", "busy cycles", n, PROG);
        for (int i = 0; i < 8; i++) m_app[i] = m_rs[i];
        m_lock = 1'b1;
        breset();
        send(8'h66); send(8'h00);
        rd("R7", stat_exp(m_lock));
        rd("R7", stat_exp(m_lock));
        breset();
        send(8'hC3); send(8'h03);
        for (int i = 0; i < 9; i++) rd("R8", m_app[wrap_a(3 + i)]);
        breset();

        // R6: writes after lock are discarded
        send(8'h99); send(8'h00);
        for (int i = 0; i < 8; i++) send(8'($urandom));
        breset();
        send(8'hC3); send(8'h00);
        for (int i = 0; i < 8; i++) rd("R6", m_app[i]);
        breset();

        // R9: second lock has no effect
        send(8'h5A); send(8'hA5);
        @(negedge clk);
        chk("R9", "busy on second lock", int'(busy), 0);
        breset();
        send(8'hC3); send(8'h00);
        for (int i = 0; i < 8; i++) rd("R9", m_app[i]);
        breset();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule